// File: doc/BRIEF.md
# Pulsed Light Dual-Window Photon Counter

This block is the digital back end of one indirect time-of-flight pixel driven by pulsed illumination. Each rising edge of the laser sync input opens a timing sequence. Two gates are derived from that edge. The full gate starts with the pulse and collects the whole returned echo. The partial gate is delayed by a programmable offset and collects only the tail of the echo. A separate saturating photon counter sits behind each gate. The ratio of the two counts encodes target distance, which is computed outside this block.

At a frame boundary, a one-cycle frame strobe copies both counts into holding registers and restarts both counters in the same edge, so acquisition of the next frame continues while the previous frame is read out (global shutter). Both gates have one programmable length. The offset of the partial gate is programmable too. All quantities are in clock cycles, and the block runs from the same 100 MHz class clock that drives readout.

Elapsed time `t` is 0 in the cycle where `laser_sync` is first seen high, and it advances by one per cycle. The window timer is a two-state machine. In `WIN_IDLE` no gate is open. The `go_open` transition is taken on a rising sync edge. `WIN_OPEN` keeps counting `t`. The `go_idle` transition is taken after the cycle with `t = shift + len - 1`, and the `restart` transition is taken when a new rising edge arrives while the timer is open. The frame latch is a two-state machine. `HOLD_STALE` is the state between frames. The `capture` transition enters `HOLD_FRESH` on a strobe. `HOLD_FRESH` lasts one cycle, or longer while strobes keep arriving, and the `age_out` transition returns to `HOLD_STALE`.

Top module: `tof_gate_counter`

## Requirements
- R1: After reset, `held_full` and `held_part` are 0 and `held_valid` is 0.
- R2: A photon in a cycle with `0 <= t < win_len` increments the full-gate count by one.
- R3: A photon in a cycle with `win_shift <= t < win_shift + win_len` increments the partial-gate count by one.
- R4: A photon outside both gates, or one arriving while no sequence is running, changes neither count.
- R5: A photon inside both gates at once increments both counts.
- R6: Each count stops at 511 (9 bits) and never wraps.
- R7: On a `frame_strobe` cycle, both counts go to the holding registers and the counters restart. A photon in that same cycle counts as 1 in the new frame.
- R8: `held_valid` is high in the cycle after a strobe and low otherwise. The held values do not change except on the edge that ends a strobe cycle.
- R9: A rising sync edge while a sequence is open restarts `t` at 0.
- R10: With `win_len = 0`, neither gate ever opens.
- R11: Only a rising edge of `laser_sync` starts a sequence. Holding it high does not retrigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| laser_sync | input | 1 | Laser pulse sync; rising edge sets t = 0 |
| photon | input | 1 | One-cycle photon detection pulse |
| win_len | input | 8 | Length of both gates in cycles |
| win_shift | input | 8 | Delay of the partial gate in cycles |
| frame_strobe | input | 1 | Frame boundary: capture and restart |
| held_full | output | 9 | Held count of the full gate |
| held_part | output | 9 | Held count of the partial gate |
| held_valid | output | 1 | High in the cycle after a capture |

## Verification
A gate decision is combinational within the photon cycle, so the counters register the photon on the next edge. The counts appear at the outputs only through a strobe. The held values and `held_valid` are due on the edge that ends the strobe cycle. The bench drives every input on the falling edge. It raises the strobe only after the last gate has closed, and it samples the outputs on the falling edge after that, one full cycle after the strobe. For each combination of length, offset and photon time in the sweep, the bench computes the expected pair of gate memberships arithmetically.

// File: rtl/tof_gate_pkg.sv
`timescale 1ns/1ps
package tof_gate_pkg;

    // Window timer states
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    // Frame latch states
    typedef enum logic {
        HOLD_STALE = 1'b0,
        HOLD_FRESH = 1'b1
    } hold_state_t;

    // Lane indices of the two gated counters
    localparam int LANE_FULL  = 0;
    localparam int LANE_PART  = 1;
    localparam int LANE_COUNT = 2;

endpackage

// File: rtl/tof_window_timer.sv
`timescale 1ns/1ps
module tof_window_timer
    import tof_gate_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             laser_sync,
    input  logic [WIN_W-1:0] win_len,
    input  logic [WIN_W-1:0] win_shift,
    output logic             gate_full,
    output logic             gate_part
);

    localparam int AGE_W = WIN_W + 1;

    win_state_t       state_q, state_d;
    logic [AGE_W-1:0] age_q, age_d;
    logic             sync_q;
    logic             rise;
    logic             active;
    logic [AGE_W-1:0] t_cur;
    logic [AGE_W-1:0] t_next;
    logic [AGE_W-1:0] t_end;
    logic [AGE_W-1:0] len_ext;
    logic [AGE_W-1:0] shift_ext;

    assign len_ext   = {1'b0, win_len};
    assign shift_ext = {1'b0, win_shift};
    assign t_end     = len_ext + shift_ext;
    assign rise      = laser_sync & ~sync_q;

    // Elapsed time of the current cycle: zero on a fresh edge
    always_comb begin
        active = 1'b0;
        t_cur  = '0;
        if (rise) begin
            active = 1'b1;
            t_cur  = '0;
        end else if (state_q == WIN_OPEN) begin
            active = 1'b1;
            t_cur  = age_q;
        end
        t_next = t_cur + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (rise && (t_next < t_end)) begin   // go_open
                    state_d = WIN_OPEN;
                    age_d   = t_next;
                end
            end
            WIN_OPEN: begin
                if (t_next < t_end) begin             // stay / restart
                    age_d = t_next;
                end else begin                        // go_idle
                    state_d = WIN_IDLE;
                    age_d   = '0;
                end
            end
            default: begin
                state_d = WIN_IDLE;
                age_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            age_q   <= '0;
            sync_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
            sync_q  <= laser_sync;
        end
    end

    // Output gates
    always_comb begin
        gate_full = 1'b0;
        gate_part = 1'b0;
        unique case (active)
            1'b1: begin
                gate_full = (t_cur < len_ext);
                gate_part = (t_cur >= shift_ext) && (t_cur < t_end);
            end
            default: begin
                gate_full = 1'b0;
                gate_part = 1'b0;
            end
        endcase
    end

    // R4: no gate while idle and no edge
    a_r4_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_IDLE && !rise) |-> (!gate_full && !gate_part));

    // R10: zero length keeps both gates shut
    a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len == '0) |-> (!gate_full && !gate_part));

    // R9: the open state never runs past the end of the partial gate
    a_r9_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_OPEN) |-> (age_q < t_end));

    // R11: a held sync level cannot re-enter the open state from idle
    a_r11_level_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_IDLE && sync_q && laser_sync) |=> (state_q == WIN_IDLE));

endmodule

// File: rtl/tof_sat_counter.sv
`timescale 1ns/1ps
module tof_sat_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q, count_d;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = inc ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
        end else if (inc && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    // R6: saturated count holds while not cleared
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !clr) |=> (count_q == CNT_MAX));

    // R7: clear with no photon leaves zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (count_q == '0));

    // R2: without clear the count moves by at most one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count_q != CNT_MAX) |=> ((count_q - $past(count_q)) <= 1));

endmodule

// File: rtl/tof_frame_latch.sv
`timescale 1ns/1ps
module tof_frame_latch
    import tof_gate_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [CNT_W-1:0] live_full,
    input  logic [CNT_W-1:0] live_part,
    output logic [CNT_W-1:0] held_full,
    output logic [CNT_W-1:0] held_part,
    output logic             held_valid
);

    hold_state_t      state_q, state_d;
    logic [CNT_W-1:0] full_q, part_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_STALE: if (strobe)  state_d = HOLD_FRESH;  // capture
            HOLD_FRESH: if (!strobe) state_d = HOLD_STALE;  // age_out
            default:    state_d = HOLD_STALE;
        endcase
    end

    // State and holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_STALE;
            full_q  <= '0;
            part_q  <= '0;
        end else begin
            state_q <= state_d;
            if (strobe) begin
                full_q <= live_full;
                part_q <= live_part;
            end
        end
    end

    // Outputs
    always_comb begin
        held_full  = full_q;
        held_part  = part_q;
        held_valid = 1'b0;
        unique case (state_q)
            HOLD_FRESH: held_valid = 1'b1;
            default:    held_valid = 1'b0;
        endcase
    end

    // R8: held values stay put between strobes
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(full_q) && $stable(part_q)));

    // R8: valid only rises after a strobe
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> held_valid);

endmodule

// File: rtl/tof_gate_counter.sv
`timescale 1ns/1ps
module tof_gate_counter
    import tof_gate_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             laser_sync,
    input  logic             photon,
    input  logic [WIN_W-1:0] win_len,
    input  logic [WIN_W-1:0] win_shift,
    input  logic             frame_strobe,
    output logic [CNT_W-1:0] held_full,
    output logic [CNT_W-1:0] held_part,
    output logic             held_valid
);

    logic [LANE_COUNT-1:0] gate;
    logic [LANE_COUNT-1:0] hit;
    logic [CNT_W-1:0]      live [LANE_COUNT];

    tof_window_timer #(.WIN_W(WIN_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .laser_sync (laser_sync),
        .win_len    (win_len),
        .win_shift  (win_shift),
        .gate_full  (gate[LANE_FULL]),
        .gate_part  (gate[LANE_PART])
    );

    // One saturating counter per gate; a photon in both gates feeds both
    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        assign hit[g] = photon & gate[g];
        tof_sat_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (frame_strobe),
            .inc   (hit[g]),
            .count (live[g])
        );
    end

    tof_frame_latch #(.CNT_W(CNT_W)) latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (frame_strobe),
        .live_full  (live[LANE_FULL]),
        .live_part  (live[LANE_PART]),
        .held_full  (held_full),
        .held_part  (held_part),
        .held_valid (held_valid)
    );

    // R5: photon in both gates reaches both counters
    a_r5_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (photon && gate[LANE_FULL] && gate[LANE_PART]) |-> (hit == 2'b11));

endmodule

// File: tb/tof_gate_counter_tb_top.sv
`timescale 1ns/1ps
module tof_gate_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       laser_sync = 1'b0;
    logic       photon = 1'b0;
    logic [7:0] win_len = '0;
    logic [7:0] win_shift = '0;
    logic       frame_strobe = 1'b0;
    logic [8:0] held_full;
    logic [8:0] held_part;
    logic       held_valid;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    tof_gate_counter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .laser_sync   (laser_sync),
        .photon       (photon),
        .win_len      (win_len),
        .win_shift    (win_shift),
        .frame_strobe (frame_strobe),
        .held_full    (held_full),
        .held_part    (held_part),
        .held_valid   (held_valid)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Strobe one cycle, then sample one cycle later on the falling edge
    task automatic strobe_and_check(input string tag, input int ef, input int ep);
        @(negedge clk);
        laser_sync = 1'b0; photon = 1'b0; frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        check({tag, " valid"}, int'(held_valid), 1);
        check({tag, " full"}, int'(held_full), ef);
        check({tag, " part"}, int'(held_part), ep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(held_valid), 0);
        check("R1 full", int'(held_full), 0);
        check("R1 part", int'(held_part), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle valid", int'(held_valid), 0);

        // R2 R3 R4 R5 R10: sweep len, shift and photon time
        for (int l = 0; l < 6; l++) begin
            for (int s = 0; s < 7; s++) begin
                for (int t = 0; t < 13; t++) begin
                    int ef, ep;
                    win_len = 8'(l);
                    win_shift = 8'(s);
                    ef = (t < l) ? 1 : 0;
                    ep = (t >= s && t < s + l) ? 1 : 0;
                    for (int k = 0; k < 16; k++) begin
                        @(negedge clk);
                        laser_sync = (k == 0);
                        photon = (k == t);
                    end
                    strobe_and_check((l == 0) ? "R10 sweep" :
                                     (ef & ep) ? "R5 sweep" :
                                     (ef | ep) ? "R2/R3 sweep" : "R4 sweep", ef, ep);
                end
            end
        end

        // R6: saturation, 60 pulses x 10 photons each in both gates
        win_len = 8'd10; win_shift = 8'd0;
        for (int p = 0; p < 60; p++) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                laser_sync = (k == 0);
                photon = (k < 10);
            end
        end
        strobe_and_check("R6 saturate", 511, 511);

        // R7: photon in the strobe cycle joins the new frame
        win_len = 8'd20; win_shift = 8'd0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            laser_sync = (k == 0);
            photon = 1'b1;
        end
        @(negedge clk);
        laser_sync = 1'b0; photon = 1'b1; frame_strobe = 1'b1;
        @(negedge clk);
        photon = 1'b0; frame_strobe = 1'b0;
        check("R7 capture full", int'(held_full), 5);
        check("R7 capture part", int'(held_part), 5);
        check("R8 valid after strobe", int'(held_valid), 1);
        // R8: held stays while counting goes on
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            photon = 1'b1;
        end
        @(negedge clk);
        photon = 1'b0;
        check("R8 valid drops", int'(held_valid), 0);
        check("R8 held stable full", int'(held_full), 5);
        check("R8 held stable part", int'(held_part), 5);
        repeat (25) @(negedge clk);
        strobe_and_check("R7 new frame", 4, 4);

        // R9: restart on a second edge
        win_len = 8'd4; win_shift = 8'd8;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            laser_sync = (k == 0) || (k == 5);
            photon = (k == 6) || (k == 13);
        end
        strobe_and_check("R9 restart", 1, 1);

        // R11: sync held high does not retrigger
        win_len = 8'd3; win_shift = 8'd0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            laser_sync = 1'b1;
            photon = (k == 1) || (k == 5) || (k == 10);
        end
        strobe_and_check("R11 level", 1, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog expired got=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule